// File: doc/BRIEF.md
# Power Controller Request/Status Engine

This block is a memory-mapped slave on a simple 32-bit register bus. It accepts frequency/voltage change requests for two CPU clusters and configuration read requests, and runs them one at a time. Each request takes a fixed, parameterised number of clock cycles. When it finishes, the block posts a completion or error flag in a shared status register and raises a level-high interrupt. Software acknowledges the interrupt by reading that register.

The block also holds the plain state that power-management software keeps beside the engine:
- a wake-up interrupt mask;
- one power-down enable per cluster;
- one resume-address mailbox per CPU;
- a read-only view of the per-CPU standby inputs.

A small computed table stands in for the configuration space behind the engine.

Top module: `pwr_req_engine`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low, and all performance, wake and power-down outputs are zero.
- R2: A request of type t is accepted on the write cycle. Type 0 is the big-cluster level write at 0x00, type 1 is the little-cluster level write at 0x08, and type 2 is a command write at 0x10 with bit 31 set. If t finishes normally, status bit 4t becomes set exactly LATENCY clock edges after the accepting edge.
- R3: A read of 0x00 or 0x08 returns the last accepted level (low LVL_W bits of the write data). `perf_big_o` and `perf_little_o` show the same value.
- R4: A command with function code 6 in bits 23:20 and a word offset w in bits 11:0 is valid when 0x304 ≤ w < 0x304+16. Let i = w−0x304. A valid command completes with status bit 8, and the read-data register at 0x74 then holds ((800+25·i)<<20) | (40000+1000·i).
- R5: A command with any other function code, or with an offset outside that range, finishes with status bit 9 instead of bit 8. The read-data register at 0x74 is left unchanged.
- R6: A request that arrives while another is in progress is dropped. Its type's error flag (bit 4t+1) is set at the next edge, a dropped level write does not change the level, and the running request finishes as normal.
- R7: `irq_o` is high whenever any status flag is set. A read of 0x18 returns the flags, and the edge at the end of that read clears them, so `irq_o` falls.
- R8: A write to 0x10 with bit 31 clear starts nothing: no flag is set and `irq_o` stays low.
- R9: The wake mask at 0x24 keeps only its implemented bits and drives them on `wake_mask_o`. Big CPU n uses bit n, little CPU n uses bit 4+n, and bits 11:10 are the global enables. With 2 big and 3 little CPUs, writing all ones reads back 0xC73.
- R10: A read of 0x3C returns big CPU n's standby input at bit n and little CPU n's standby input at bit 3+n. All other bits read zero.
- R11: Bit 0 written to 0x30 (big) and to 0x34 (little) sets that cluster's power-down enable. The register reads back that bit, and the enable drives `pwrdn_big_o` or `pwrdn_little_o`.
- R12: Each CPU has a 32-bit resume-address mailbox that reads back what was written. Big CPU n is at 0x68+4n and little CPU n is at 0x78+4n. The configuration write-data register at 0x70 also reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (only a status read has a side effect) |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| standby_big_i | input | BIG_CPUS | Standby state of the big-cluster CPUs |
| standby_little_i | input | LITTLE_CPUS | Standby state of the little-cluster CPUs |
| irq_o | output | 1 | Level interrupt, high while any status flag is set |
| perf_big_o | output | LVL_W | Current big-cluster level |
| perf_little_o | output | LVL_W | Current little-cluster level |
| wake_mask_o | output | 12 | Wake-up interrupt mask |
| pwrdn_big_o | output | 1 | Big-cluster power-down enable |
| pwrdn_little_o | output | 1 | Little-cluster power-down enable |

## Verification
The hardest case to reach from the ports is a collision: a request arriving during the few cycles in which another one is running. It matters most when the late request is of the same type and would overwrite a level, or when a status read lands close to a finish. Directed writes placed back to back on consecutive cycles create that overlap deliberately. Randomised rounds then mix the request types, the level values, valid and invalid configuration offsets, and wrong function codes, and predict every flag and data word from the requirement formulas.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
  timeunit 1ns; timeprecision 100ps;

  typedef enum logic [1:0] {
    REQ_BIG    = 2'd0,
    REQ_LITTLE = 2'd1,
    REQ_CFG    = 2'd2
  } req_type_e;

  localparam int unsigned NUM_TYPES = 3;
  localparam int unsigned STAT_W    = 4 * NUM_TYPES;

  // word addresses (byte address >> 2)
  localparam logic [9:0] W_PERF_BIG  = 10'h000;
  localparam logic [9:0] W_PERF_LIT  = 10'h002;
  localparam logic [9:0] W_CMD       = 10'h004;
  localparam logic [9:0] W_STATUS    = 10'h006;
  localparam logic [9:0] W_WAKE      = 10'h009;
  localparam logic [9:0] W_PD_BIG    = 10'h00C;
  localparam logic [9:0] W_PD_LIT    = 10'h00D;
  localparam logic [9:0] W_STANDBY   = 10'h00F;
  localparam logic [9:0] W_MBOX_BIG  = 10'h01A;
  localparam logic [9:0] W_CFG_WDATA = 10'h01C;
  localparam logic [9:0] W_CFG_RDATA = 10'h01D;
  localparam logic [9:0] W_MBOX_LIT  = 10'h01E;

  function automatic logic [31:0] cfg_entry(input int unsigned idx);
    logic [11:0] volt;
    logic [19:0] freq;
    volt = 12'(800 + 25 * idx);
    freq = 20'(40000 + 1000 * idx);
    return {volt, freq};
  endfunction
endpackage

// File: rtl/pwr_cfg_rom.sv
module pwr_cfg_rom
  import pwr_req_pkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned BASE_WORD = 12'h304,
  parameter int unsigned FUNC      = 6
) (
  input  logic [31:0] cmd_i,
  output logic        hit_o,
  output logic [31:0] data_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned OFF_W = 12;

  logic [OFF_W-1:0] word;
  logic [OFF_W-1:0] idx;
  logic             in_range;

  assign word     = cmd_i[OFF_W-1:0];
  assign idx      = word - OFF_W'(BASE_WORD);
  assign in_range = (word >= OFF_W'(BASE_WORD)) && (idx < OFF_W'(ENTRIES));
  assign hit_o    = in_range && (cmd_i[23:20] == 4'(FUNC));
  assign data_o   = hit_o ? cfg_entry(int'(idx)) : '0;
endmodule

// File: rtl/pwr_req_seq.sv
module pwr_req_seq
  import pwr_req_pkg::*;
#(
  parameter int unsigned LATENCY = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  req_type_e         type_i,
  input  logic              fail_i,
  input  logic              clr_i,
  output logic              busy_o,
  output req_type_e         cur_type_o,
  output logic              fin_o,
  output logic [STAT_W-1:0] status_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned CNT_W = $clog2(LATENCY + 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  req_type_e         type_q;
  logic [STAT_W-1:0] status_q, status_d;
  logic              fin, accept, reject;

  assign fin    = busy_q && (cnt_q == '0);
  assign accept = start_i && !busy_q;
  assign reject = start_i && busy_q;

  always_comb begin
    status_d = clr_i ? '0 : status_q;
    if (fin)    status_d[4 * int'(type_q) + int'(fail_i)] = 1'b1;
    if (reject) status_d[4 * int'(type_i) + 1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      type_q   <= REQ_BIG;
      status_q <= '0;
    end else begin
      status_q <= status_d;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(LATENCY - 1);
        type_q <= type_i;
      end else if (fin) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign cur_type_o = type_q;
  assign fin_o      = fin;
  assign status_o   = status_q;

  assert_start_from_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
  assert_busy_keeps_type_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_q && cnt_q != '0) |=> (busy_q && $stable(type_q)));
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !busy_q && !start_i) |=> (status_q == '0));
endmodule

// File: rtl/pwr_req_engine.sv
module pwr_req_engine
  import pwr_req_pkg::*;
#(
  parameter int unsigned LATENCY     = 6,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned BIG_CPUS    = 2,  // <= 2 to fit below the cfg data words
  parameter int unsigned LITTLE_CPUS = 3,  // <= 4
  parameter int unsigned CFG_ENTRIES = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [11:0]            addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  input  logic [BIG_CPUS-1:0]    standby_big_i,
  input  logic [LITTLE_CPUS-1:0] standby_little_i,
  output logic                   irq_o,
  output logic [LVL_W-1:0]       perf_big_o,
  output logic [LVL_W-1:0]       perf_little_o,
  output logic [11:0]            wake_mask_o,
  output logic                   pwrdn_big_o,
  output logic                   pwrdn_little_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam logic [11:0] WAKE_BITS = 12'hC00
    | 12'(((1 << LITTLE_CPUS) - 1) << 4) | 12'((1 << BIG_CPUS) - 1);

  logic [9:0] word;
  logic       wr_pbig, wr_plit, wr_cmd, start, busy, fin, hit, fail;
  req_type_e  start_type, cur_type;
  logic [STAT_W-1:0] status;
  logic [31:0] rom_data;

  logic [LVL_W-1:0] perf_big_q, perf_lit_q;
  logic [31:0]      cmd_q, cfg_wd_q, cfg_rd_q;
  logic [11:0]      wake_q;
  logic             pd_big_q, pd_lit_q;
  logic [31:0]      mbox_big_q [BIG_CPUS];
  logic [31:0]      mbox_lit_q [LITTLE_CPUS];

  assign word    = addr_i[11:2];
  assign wr_pbig = wr_en_i && (word == W_PERF_BIG);
  assign wr_plit = wr_en_i && (word == W_PERF_LIT);
  assign wr_cmd  = wr_en_i && (word == W_CMD) && wdata_i[31];
  assign start   = wr_pbig || wr_plit || wr_cmd;
  assign start_type = wr_cmd ? REQ_CFG : (wr_plit ? REQ_LITTLE : REQ_BIG);
  assign fail    = (cur_type == REQ_CFG) && !hit;

  pwr_req_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .type_i(start_type), .fail_i(fail),
    .clr_i(rd_en_i && (word == W_STATUS)),
    .busy_o(busy), .cur_type_o(cur_type), .fin_o(fin), .status_o(status)
  );

  pwr_cfg_rom #(.ENTRIES(CFG_ENTRIES)) u_rom (
    .cmd_i(cmd_q), .hit_o(hit), .data_o(rom_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perf_big_q <= '0;
      perf_lit_q <= '0;
      cmd_q      <= '0;
      cfg_wd_q   <= '0;
      cfg_rd_q   <= '0;
      wake_q     <= '0;
      pd_big_q   <= 1'b0;
      pd_lit_q   <= 1'b0;
    end else begin
      if (wr_pbig && !busy) perf_big_q <= wdata_i[LVL_W-1:0];
      if (wr_plit && !busy) perf_lit_q <= wdata_i[LVL_W-1:0];
      if (wr_cmd && !busy)  cmd_q <= wdata_i;
      if (fin && cur_type == REQ_CFG && hit) cfg_rd_q <= rom_data;
      if (wr_en_i && word == W_CFG_WDATA) cfg_wd_q <= wdata_i;
      if (wr_en_i && word == W_WAKE)      wake_q   <= wdata_i[11:0] & WAKE_BITS;
      if (wr_en_i && word == W_PD_BIG)    pd_big_q <= wdata_i[0];
      if (wr_en_i && word == W_PD_LIT)    pd_lit_q <= wdata_i[0];
    end
  end

  for (genvar g = 0; g < BIG_CPUS; g++) begin : g_mbox_big
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mbox_big_q[g] <= '0;
      else if (wr_en_i && word == W_MBOX_BIG + 10'(g)) mbox_big_q[g] <= wdata_i;
    end
  end

  for (genvar g = 0; g < LITTLE_CPUS; g++) begin : g_mbox_lit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mbox_lit_q[g] <= '0;
      else if (wr_en_i && word == W_MBOX_LIT + 10'(g)) mbox_lit_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (word)
      W_PERF_BIG:  rdata_o = 32'(perf_big_q);
      W_PERF_LIT:  rdata_o = 32'(perf_lit_q);
      W_CMD:       rdata_o = cmd_q;
      W_STATUS:    rdata_o = 32'(status);
      W_WAKE:      rdata_o = 32'(wake_q);
      W_PD_BIG:    rdata_o = 32'(pd_big_q);
      W_PD_LIT:    rdata_o = 32'(pd_lit_q);
      W_STANDBY: begin
        rdata_o[BIG_CPUS-1:0]   = standby_big_i;
        rdata_o[3 +: LITTLE_CPUS] = standby_little_i;
      end
      W_CFG_WDATA: rdata_o = cfg_wd_q;
      W_CFG_RDATA: rdata_o = cfg_rd_q;
      default: begin
        for (int i = 0; i < BIG_CPUS; i++)
          if (word == W_MBOX_BIG + 10'(i)) rdata_o = mbox_big_q[i];
        for (int i = 0; i < LITTLE_CPUS; i++)
          if (word == W_MBOX_LIT + 10'(i)) rdata_o = mbox_lit_q[i];
      end
    endcase
  end

  assign irq_o          = |status;
  assign perf_big_o     = perf_big_q;
  assign perf_little_o  = perf_lit_q;
  assign wake_mask_o    = wake_q;
  assign pwrdn_big_o    = pd_big_q;
  assign pwrdn_little_o = pd_lit_q;

  assert_level_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pbig && busy) |=> $stable(perf_big_q));
  assert_rdata_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_rd_q) |-> $past(fin && cur_type == REQ_CFG && hit));
  assert_irq_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fin || start));
endmodule

// File: tb/pwr_req_engine_test.sv
module pwr_req_engine_test;
  timeunit 1ns; timeprecision 100ps;

  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  sb_big = '0;
  logic [2:0]  sb_lit = '0;
  logic        irq, pd_big, pd_lit;
  logic [2:0]  pbig, plit;
  logic [11:0] wake;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_rd = 0;

  always #5 clk = ~clk;

  pwr_req_engine #(.LATENCY(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .standby_big_i(sb_big), .standby_little_i(sb_lit), .irq_o(irq),
    .perf_big_o(pbig), .perf_little_o(plit), .wake_mask_o(wake),
    .pwrdn_big_o(pd_big), .pwrdn_little_o(pd_lit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg_val(input int i);
    return ((32'(800 + 25 * i)) << 20) | 32'(40000 + 1000 * i);
  endfunction

  function automatic bit cfg_ok(input logic [31:0] cmd);
    return cmd[23:20] == 4'd6 && cmd[11:0] >= 12'h304 && cmd[11:0] < 12'h314;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(12'h018, v); chk("R1 status", v, 0);
    rd(12'h000, v); chk("R1 perf big", v, 0);
    rd(12'h024, v); chk("R1 wake", v, 0);
    rd(12'h074, v); chk("R1 cfg rdata", v, 0);
    chk("R1 outputs", {pd_big, pd_lit, pbig, plit, wake}, 0);

    // R2 exact latency, R3 readback, R7 clear on read
    wr(12'h000, 32'd5);
    idle(LAT);
    chk("R2 not early", 32'(irq), 0);
    idle(1);
    chk("R2 on time", 32'(irq), 1);
    rd(12'h018, v); chk("R2 status bit0", v, 32'h001);
    chk("R7 irq cleared", 32'(irq), 0);
    rd(12'h018, v); chk("R7 status cleared", v, 0);
    rd(12'h000, v); chk("R3 level readback", v, 5);
    chk("R3 perf_big_o", 32'(pbig), 5);

    // R6 back-to-back collision of the same type
    wr(12'h000, 32'd3);
    wr(12'h000, 32'd6);
    rd(12'h018, v); chk("R6 error flag", v, 32'h002);
    rd(12'h000, v); chk("R6 level kept", v, 3);
    idle(LAT + 1);
    rd(12'h018, v); chk("R6 first finishes", v, 32'h001);

    // R6 collision across types: little level then cfg
    wr(12'h008, 32'd2);
    wr(12'h010, 32'h8060_0304);
    idle(LAT + 1);
    rd(12'h018, v); chk("R6 cross type", v, 32'h210);
    rd(12'h074, v); chk("R6 cfg not run", v, 0);

    // R8 no start bit
    wr(12'h010, 32'h0060_0305);
    idle(LAT + 2);
    chk("R8 irq low", 32'(irq), 0);
    rd(12'h018, v); chk("R8 status", v, 0);

    // R4 boundaries, R5 errors
    wr(12'h010, 32'h8060_0304); idle(LAT + 1);
    rd(12'h018, v); chk("R4 first entry", v, 32'h100);
    rd(12'h074, v); chk("R4 data first", v, cfg_val(0)); exp_rd = cfg_val(0);
    wr(12'h010, 32'h8060_0313); idle(LAT + 1);
    rd(12'h018, v); chk("R4 last entry", v, 32'h100);
    rd(12'h074, v); chk("R4 data last", v, cfg_val(15)); exp_rd = cfg_val(15);
    wr(12'h010, 32'h8060_0314); idle(LAT + 1);
    rd(12'h018, v); chk("R5 past end", v, 32'h200);
    rd(12'h074, v); chk("R5 data kept", v, exp_rd);
    wr(12'h010, 32'h8060_0303); idle(LAT + 1);
    rd(12'h018, v); chk("R5 before base", v, 32'h200);
    wr(12'h010, 32'h8050_0306); idle(LAT + 1);
    rd(12'h018, v); chk("R5 bad func", v, 32'h200);
    rd(12'h074, v); chk("R5 data kept func", v, exp_rd);

    // randomised rounds
    for (int it = 0; it < 30; it++) begin
      int k;
      k = int'($urandom % 3);
      if (k < 2) begin
        logic [2:0] lvl;
        lvl = 3'($urandom);
        wr(k == 0 ? 12'h000 : 12'h008, {29'($urandom), lvl});
        idle(LAT + 1);
        rd(12'h018, v); chk("R2 random level", v, k == 0 ? 32'h001 : 32'h010);
        rd(k == 0 ? 12'h000 : 12'h008, v); chk("R3 random level", v, 32'(lvl));
        chk("R3 random out", 32'(k == 0 ? pbig : plit), 32'(lvl));
      end else begin
        logic [31:0] cmd;
        cmd = 32'h8000_0000 | ((($urandom % 4) == 0 ? 32'd5 : 32'd6) << 20)
              | (32'h300 + ($urandom % 24));
        wr(12'h010, cmd);
        idle(LAT + 1);
        if (cfg_ok(cmd)) exp_rd = cfg_val(int'(cmd[11:0]) - 'h304);
        rd(12'h018, v); chk(cfg_ok(cmd) ? "R4 random" : "R5 random", v,
                            cfg_ok(cmd) ? 32'h100 : 32'h200);
        rd(12'h074, v); chk("R4 R5 random data", v, exp_rd);
      end
    end

    // R9 wake mask
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h024, v); chk("R9 wake all ones", v, 32'hC73);
    chk("R9 wake out", 32'(wake), 32'hC73);
    wr(12'h024, 32'h0000_0412);
    rd(12'h024, v); chk("R9 wake pattern", v, 32'h412);

    // R10 standby mapping
    sb_big = 2'b10; sb_lit = 3'b101;
    rd(12'h03C, v); chk("R10 standby", v, 32'h2A);
    sb_big = 2'b01; sb_lit = 3'b010;
    rd(12'h03C, v); chk("R10 standby alt", v, 32'h11);

    // R11 power-down enables
    wr(12'h030, 32'h1);
    wr(12'h034, 32'hFFFF_FFFE);
    rd(12'h030, v); chk("R11 big", v, 1);
    rd(12'h034, v); chk("R11 little", v, 0);
    chk("R11 outputs", {pd_big, pd_lit}, 32'b10);

    // R12 mailboxes and cfg write data
    begin
      logic [31:0] m [6];
      logic [11:0] a [6];
      a = '{12'h068, 12'h06C, 12'h078, 12'h07C, 12'h080, 12'h070};
      foreach (m[i]) begin m[i] = $urandom; wr(a[i], m[i]); end
      foreach (m[i]) begin rd(a[i], v); chk("R12 mailbox", v, m[i]); end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule